// File: doc/BRIEF.md
# SMBus Target Command Dispatcher

This block sits behind an SMBus target's bit-level engine, which handles start and stop detection, byte shifting and the slave address match. The engine reports a start, a stop, each received byte with its position in the frame (position 0 is the command byte), and a request for a read byte. The dispatcher uses these events to decide what the host meant. It gives the ACK or NACK for every received byte, keeps the shared access pointer, and issues single-beat write and read requests to a storage backend that holds both a RAM space and a nonvolatile space.

The kind of write frame is chosen by the command code and by how many bytes follow it. A frame that holds only a command byte selects a RAM location. A command from 0xF8 to 0xFB gives the upper byte of a nonvolatile address. One further byte gives the lower byte and only moves the pointer. Two further bytes also program the second byte at that address. The choice between these two cases is made at the stop. Command 0xFC opens a counted block write. Its data bytes are forwarded as they arrive, to consecutive addresses in the space the pointer currently selects. A read request fetches the byte at the pointer and returns it to the engine.

Top module: `smb_cmd_dispatch`

## Requirements
- R1: After reset no backend request is active, no read data is valid, and the pointer is address 0x0000 in RAM space.
- R2: A frame whose only byte is a command (of any value) loads the pointer with 0x00 followed by the command value in RAM space, and it issues no write.
- R3: A command from 0xF8 to 0xFB followed by exactly one byte sets the pointer, at the stop, to the address whose upper byte is the command and whose lower byte is the data byte, in nonvolatile space. It issues no write.
- R4: A command from 0xF8 to 0xFB followed by exactly two bytes issues one nonvolatile write at the stop. The upper address byte is the command, the lower address byte is the first data byte, and the value is the second data byte. The pointer is left at that address.
- R5: Command 0xFC is followed by a count N. When N is from 1 to 32, the count and all N data bytes are ACKed. Each data byte is written, in the cycle after it arrives, to the pointer in its current space, and the pointer then increments by one.
- R6: A block count of 0 or of more than 32 is NACKed. Every later byte of that frame is NACKed, nothing is written, and the pointer does not change.
- R7: A stop that arrives before N block bytes have been received ends the block. Bytes already written remain written, and the pointer stays just past the last of them.
- R8: Data bytes received after the Nth block byte are NACKed and are not written.
- R9: A read request issues a backend read of the pointer address and space in the next cycle. The returned byte is presented on the read data output with a one-cycle valid strobe.
- R10: The command byte is always ACKed. A data byte after a command outside 0xF8 to 0xFC is NACKed, and that frame leaves the pointer unchanged.
- R11: A start received before the stop discards a pending nonvolatile frame: no write is issued and the pointer is unchanged.
- R12: A third data byte after a 0xF8 to 0xFB command is NACKed, and the frame then neither writes nor moves the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated start seen |
| stop_i | input | 1 | Stop seen |
| byte_vld_i | input | 1 | A received byte is present |
| byte_i | input | 8 | Received byte |
| byte_pos_i | input | POS_W | Position of the byte after the address byte (0 = command) |
| rd_req_i | input | 1 | Engine needs a byte to transmit |
| ack_o | output | 1 | ACK (1) or NACK (0) for the present byte |
| rd_data_o | output | 8 | Byte to transmit |
| rd_vld_o | output | 1 | rd_data_o updated this cycle |
| be_wr_o | output | 1 | Backend write strobe |
| be_rd_o | output | 1 | Backend read strobe |
| be_nv_o | output | 1 | Request targets nonvolatile space (1) or RAM (0) |
| be_addr_o | output | 16 | Request address |
| be_wdata_o | output | 8 | Write data |
| be_rdata_i | input | 8 | Backend read data |
| be_rvld_i | input | 1 | Backend read data valid |

## Verification
On every cycle, the assertions check that a command byte is always ACKed. They check that a rejected block count sends the frame to the discard state and that the remaining block count never goes above the limit. They also check that the pointer holds or steps by exactly one when it is not loaded, and that every read request yields a backend read in the next cycle. Only the bench scenarios can show the rest, because each depends on a whole frame: which frame length turns into a pointer move and which into a program write; the order, addresses and data of the block writes; aborts by an early stop or a repeated start; and the pointer seen afterwards through the read path.

// File: rtl/smb_disp_pkg.sv
package smb_disp_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    FK_IDLE,
    FK_CMD,
    FK_NV,
    FK_BCNT,
    FK_BDAT,
    FK_BAD
  } frame_kind_e;

  typedef struct packed {
    logic              ram_ptr;
    logic              nv_ptr;
    logic              nv_prog;
    logic              blk_wr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } disp_act_t;
endpackage

// File: rtl/smb_frame_dec.sv
module smb_frame_dec
  import smb_disp_pkg::*;
#(
  parameter logic [7:0] NV_HI_MIN = 8'hF8,
  parameter logic [7:0] NV_HI_MAX = 8'hFB,
  parameter logic [7:0] BLK_CMD   = 8'hFC,
  parameter int         MAX_BLK   = 32,
  parameter int         POS_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [POS_W-1:0] byte_pos_i,
  output logic             ack_o,
  output disp_act_t        act_o
);
  localparam int                CNT_W    = $clog2(MAX_BLK + 1);
  localparam logic [7:0]        MAX_B8   = 8'(MAX_BLK);
  localparam logic [CNT_W-1:0]  LEFT_MAX = CNT_W'(MAX_BLK);

  frame_kind_e      kind_q, kind_d;
  logic [7:0]       cmd_q, cmd_d, lo_q, lo_d, dat_q, dat_d;
  logic [1:0]       ndat_q, ndat_d;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    kind_d = kind_q;
    cmd_d  = cmd_q;
    lo_d   = lo_q;
    dat_d  = dat_q;
    ndat_d = ndat_q;
    left_d = left_q;
    ack_o  = 1'b0;
    act_o  = '0;
    if (start_i) begin
      kind_d = FK_IDLE;
    end else if (stop_i) begin
      kind_d = FK_IDLE;
      unique case (kind_q)
        FK_CMD, FK_BCNT: begin
          act_o.ram_ptr = 1'b1;
          act_o.addr    = {8'h00, cmd_q};
        end
        FK_NV: begin
          act_o.addr = {cmd_q, lo_q};
          act_o.data = dat_q;
          if (ndat_q == 2'd0) begin
            act_o.ram_ptr = 1'b1;
            act_o.addr    = {8'h00, cmd_q};
          end else if (ndat_q == 2'd1) begin
            act_o.nv_ptr = 1'b1;
          end else begin
            act_o.nv_prog = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (byte_vld_i) begin
      if (byte_pos_i == '0) begin
        ack_o  = 1'b1;
        cmd_d  = byte_i;
        ndat_d = 2'd0;
        if (byte_i == BLK_CMD)                             kind_d = FK_BCNT;
        else if (byte_i >= NV_HI_MIN && byte_i <= NV_HI_MAX) kind_d = FK_NV;
        else                                               kind_d = FK_CMD;
      end else begin
        unique case (kind_q)
          FK_NV: begin
            if (ndat_q == 2'd0) begin
              ack_o = 1'b1; lo_d = byte_i; ndat_d = 2'd1;
            end else if (ndat_q == 2'd1) begin
              ack_o = 1'b1; dat_d = byte_i; ndat_d = 2'd2;
            end else begin
              kind_d = FK_BAD;
            end
          end
          FK_BCNT: begin
            if (byte_i == 8'h00 || byte_i > MAX_B8) begin
              kind_d = FK_BAD;
            end else begin
              ack_o  = 1'b1;
              left_d = byte_i[CNT_W-1:0];
              kind_d = FK_BDAT;
            end
          end
          FK_BDAT: begin
            if (left_q != '0) begin
              ack_o        = 1'b1;
              act_o.blk_wr = 1'b1;
              act_o.data   = byte_i;
              left_d       = left_q - 1'b1;
            end else begin
              kind_d = FK_BAD;
            end
          end
          FK_CMD:  kind_d = FK_BAD;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= FK_IDLE;
      cmd_q  <= '0;
      lo_q   <= '0;
      dat_q  <= '0;
      ndat_q <= '0;
      left_q <= '0;
    end else begin
      kind_q <= kind_d;
      cmd_q  <= cmd_d;
      lo_q   <= lo_d;
      dat_q  <= dat_d;
      ndat_q <= ndat_d;
      left_q <= left_d;
    end
  end

  p_cmd_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && !stop_i && byte_pos_i == '0) |-> ack_o);

  p_bad_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !start_i && !stop_i && byte_pos_i != '0 && kind_q == FK_BCNT
     && (byte_i == 8'h00 || byte_i > MAX_B8)) |=> (kind_q == FK_BAD));

  p_left_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == FK_BDAT) |-> (left_q <= LEFT_MAX));
endmodule

// File: rtl/smb_ptr_unit.sv
module smb_ptr_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_ld_i,
  input  logic              nv_ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              nv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      nv_o  <= 1'b0;
    end else if (ram_ld_i || nv_ld_i) begin
      ptr_o <= ld_addr_i;
      nv_o  <= nv_ld_i;
    end else if (inc_i) begin
      ptr_o <= ptr_o + 1'b1;
    end
  end

  p_ptr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ld_i && !nv_ld_i && !inc_i) |=> ($stable(ptr_o) && $stable(nv_o)));

  p_blk_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ram_ld_i && !nv_ld_i) |=> (ptr_o == $past(ptr_o) + 1'b1));
endmodule

// File: rtl/smb_be_req.sv
module smb_be_req #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              blk_wr_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              ptr_nv_i,
  input  logic [7:0]        be_rdata_i,
  input  logic              be_rvld_i,
  output logic              be_wr_o,
  output logic              be_rd_o,
  output logic              be_nv_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [7:0]        be_wdata_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_wr_o    <= 1'b0;
      be_rd_o    <= 1'b0;
      be_nv_o    <= 1'b0;
      be_addr_o  <= '0;
      be_wdata_o <= '0;
    end else begin
      be_rd_o <= rd_req_i;
      be_wr_o <= !rd_req_i && (blk_wr_i || prog_i);
      if (rd_req_i || blk_wr_i) begin
        be_addr_o <= ptr_i;
        be_nv_o   <= ptr_nv_i;
      end else if (prog_i) begin
        be_addr_o <= prog_addr_i;
        be_nv_o   <= 1'b1;
      end
      if (blk_wr_i || prog_i) be_wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else begin
      rd_vld_o <= be_rvld_i;
      if (be_rvld_i) rd_data_o <= be_rdata_i;
    end
  end

  p_rd_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (be_rd_o && !be_wr_o));
endmodule

// File: rtl/smb_cmd_dispatch.sv
module smb_cmd_dispatch
  import smb_disp_pkg::*;
#(
  parameter logic [7:0] NV_HI_MIN = 8'hF8,
  parameter logic [7:0] NV_HI_MAX = 8'hFB,
  parameter logic [7:0] BLK_CMD   = 8'hFC,
  parameter int         MAX_BLK   = 32,
  parameter int         POS_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [POS_W-1:0]  byte_pos_i,
  input  logic              rd_req_i,
  output logic              ack_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o,
  output logic              be_wr_o,
  output logic              be_rd_o,
  output logic              be_nv_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [7:0]        be_wdata_o,
  input  logic [7:0]        be_rdata_i,
  input  logic              be_rvld_i
);
  disp_act_t         act;
  logic [ADDR_W-1:0] ptr;
  logic              ptr_nv;

  smb_frame_dec #(
    .NV_HI_MIN (NV_HI_MIN),
    .NV_HI_MAX (NV_HI_MAX),
    .BLK_CMD   (BLK_CMD),
    .MAX_BLK   (MAX_BLK),
    .POS_W     (POS_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .byte_pos_i (byte_pos_i),
    .ack_o      (ack_o),
    .act_o      (act)
  );

  smb_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ram_ld_i  (act.ram_ptr),
    .nv_ld_i   (act.nv_ptr || act.nv_prog),
    .ld_addr_i (act.addr),
    .inc_i     (act.blk_wr),
    .ptr_o     (ptr),
    .nv_o      (ptr_nv)
  );

  smb_be_req #(.ADDR_W(ADDR_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req_i),
    .blk_wr_i    (act.blk_wr),
    .prog_i      (act.nv_prog),
    .prog_addr_i (act.addr),
    .wdata_i     (act.data),
    .ptr_i       (ptr),
    .ptr_nv_i    (ptr_nv),
    .be_rdata_i  (be_rdata_i),
    .be_rvld_i   (be_rvld_i),
    .be_wr_o     (be_wr_o),
    .be_rd_o     (be_rd_o),
    .be_nv_o     (be_nv_o),
    .be_addr_o   (be_addr_o),
    .be_wdata_o  (be_wdata_o),
    .rd_data_o   (rd_data_o),
    .rd_vld_o    (rd_vld_o)
  );
endmodule

// File: tb/smb_cmd_dispatch_bench.sv
`timescale 1ns/1ps
module smb_cmd_dispatch_bench;
  localparam int POS_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, rd_req_i = 0;
  logic [7:0] byte_i = '0;
  logic [POS_W-1:0] byte_pos_i = '0;
  logic ack_o, rd_vld_o, be_wr_o, be_rd_o, be_nv_o;
  logic [7:0] rd_data_o, be_wdata_o;
  logic [15:0] be_addr_o;
  logic [7:0] be_rdata_i = '0;
  logic be_rvld_i = 1'b0;

  always #2.5 clk = ~clk;

  smb_cmd_dispatch u_smb_cmd_dispatch (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .byte_pos_i(byte_pos_i),
    .rd_req_i(rd_req_i), .ack_o(ack_o), .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o),
    .be_wr_o(be_wr_o), .be_rd_o(be_rd_o), .be_nv_o(be_nv_o), .be_addr_o(be_addr_o),
    .be_wdata_o(be_wdata_o), .be_rdata_i(be_rdata_i), .be_rvld_i(be_rvld_i)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a, input logic nv);
    return a[7:0] ^ a[15:8] ^ (nv ? 8'h5A : 8'h00);
  endfunction

  // backend model: one-cycle read latency
  always @(posedge clk) begin
    be_rvld_i  <= be_rd_o;
    be_rdata_i <= mem_val(be_addr_o, be_nv_o);
  end

  // write log, sampled away from the clock edge
  int wr_cnt = 0;
  logic [15:0] wa [0:1023];
  logic [7:0]  wd [0:1023];
  logic        wn [0:1023];
  always @(negedge clk) begin
    if (be_wr_o && wr_cnt < 1024) begin
      wa[wr_cnt] = be_addr_o;
      wd[wr_cnt] = be_wdata_o;
      wn[wr_cnt] = be_nv_o;
      wr_cnt++;
    end
  end

  int checks = 0, fails = 0;
  logic [15:0] exp_ptr = '0;
  logic        exp_nv  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk); start_i = 1;
    @(posedge clk); #1 start_i = 0;
  endtask

  task automatic ev_stop();
    @(negedge clk); stop_i = 1;
    @(posedge clk); #1 stop_i = 0;
    @(negedge clk);
  endtask

  task automatic ev_byte(input int pos, input logic [7:0] b, output logic ack);
    @(negedge clk); byte_vld_i = 1; byte_i = b; byte_pos_i = POS_W'(pos);
    #1 ack = ack_o;
    @(posedge clk); #1 byte_vld_i = 0;
  endtask

  // read through the normal path; checks address, space and returned byte
  task automatic read_ptr(input string req);
    logic got;
    @(negedge clk); rd_req_i = 1;
    @(posedge clk); #1 rd_req_i = 0;
    @(negedge clk);
    chk(be_rd_o === 1'b1, req, 32'(be_rd_o), 1);
    chk(be_addr_o === exp_ptr && be_nv_o === exp_nv, req,
        {15'd0, be_nv_o, be_addr_o}, {15'd0, exp_nv, exp_ptr});
    got = 0;
    for (int i = 0; i < 4 && !got; i++) begin
      @(negedge clk);
      if (rd_vld_o) got = 1;
    end
    chk(got && rd_data_o === mem_val(exp_ptr, exp_nv), req,
        32'(rd_data_o), 32'(mem_val(exp_ptr, exp_nv)));
  endtask

  task automatic set_nv_ptr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    ev_start(); ev_byte(0, hi, a); ev_byte(1, lo, a); ev_stop();
    exp_ptr = {hi, lo}; exp_nv = 1;
  endtask

  task automatic set_ram_ptr(input logic [7:0] c);
    logic a;
    ev_start(); ev_byte(0, c, a); ev_stop();
    exp_ptr = {8'h00, c}; exp_nv = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!be_wr_o && !be_rd_o && !rd_vld_o, "R1", {be_wr_o, be_rd_o, rd_vld_o}, 0);
    rst_ni = 1;
    read_ptr("R1");

    // R2 / R10: every bare command loads a RAM pointer
    for (int c = 0; c < 256; c++) begin
      base = wr_cnt;
      ev_start(); ev_byte(0, 8'(c), a);
      chk(a === 1'b1, "R10", 32'(a), 1);
      ev_stop();
      exp_ptr = {8'h00, 8'(c)}; exp_nv = 0;
      chk(wr_cnt == base, "R2", wr_cnt - base, 0);
      read_ptr("R2");
    end

    // R3: nonvolatile pointer setup
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        logic [7:0] lo;
        lo = 8'(l * 85 + 3);
        base = wr_cnt;
        ev_start(); ev_byte(0, 8'hF8 + 8'(h), a);
        ev_byte(1, lo, a);
        chk(a === 1'b1, "R3", 32'(a), 1);
        ev_stop();
        exp_ptr = {8'hF8 + 8'(h), lo}; exp_nv = 1;
        chk(wr_cnt == base, "R3", wr_cnt - base, 0);
        read_ptr("R3");
      end
    end

    // R4: single-byte program
    for (int i = 0; i < 8; i++) begin
      logic [7:0] hi, lo, d;
      hi = 8'hF8 + 8'(i % 4); lo = 8'(i * 37); d = 8'(i * 11 + 3);
      set_ram_ptr(8'h40);
      base = wr_cnt;
      ev_start(); ev_byte(0, hi, a); ev_byte(1, lo, a); ev_byte(2, d, a);
      chk(a === 1'b1, "R4", 32'(a), 1);
      chk(wr_cnt == base, "R4", wr_cnt - base, 0);
      ev_stop(); @(negedge clk);
      chk(wr_cnt == base + 1, "R4", wr_cnt - base, 1);
      chk(wa[base] == {hi, lo} && wd[base] == d && wn[base] == 1'b1, "R4",
          {7'd0, wn[base], wd[base], wa[base]}, {8'd1, d, hi, lo});
      exp_ptr = {hi, lo}; exp_nv = 1;
      read_ptr("R4");
    end

    // R5: block writes of every legal length, both spaces
    for (int n = 1; n <= 32; n++) begin
      if (n % 2 == 1) set_nv_ptr(8'hF8 + 8'(n % 4), 8'(n * 7));
      else            set_ram_ptr(8'(n * 5));
      base = wr_cnt;
      ev_start(); ev_byte(0, 8'hFC, a);
      ev_byte(1, 8'(n), a);
      chk(a === 1'b1, "R5", 32'(a), 1);
      for (int j = 0; j < n; j++) begin
        ev_byte(2 + j, 8'(n + j), a);
        chk(a === 1'b1, "R5", 32'(a), 1);
      end
      ev_stop();
      chk(wr_cnt == base + n, "R5", wr_cnt - base, n);
      for (int j = 0; j < n; j++)
        chk(wa[base+j] == exp_ptr + 16'(j) && wd[base+j] == 8'(n + j) && wn[base+j] == exp_nv,
            "R5", {7'd0, wn[base+j], wd[base+j], wa[base+j]},
            {7'd0, exp_nv, 8'(n + j), exp_ptr + 16'(j)});
      exp_ptr = exp_ptr + 16'(n);
      read_ptr("R5");
    end

    // R6: illegal counts
    set_ram_ptr(8'h21);
    for (int c = 0; c < 256; c++) begin
      if (c >= 1 && c <= 32) continue;
      base = wr_cnt;
      ev_start(); ev_byte(0, 8'hFC, a);
      ev_byte(1, 8'(c), a);
      chk(a === 1'b0, "R6", 32'(a), 0);
      ev_byte(2, 8'h77, a);
      chk(a === 1'b0, "R6", 32'(a), 0);
      ev_stop();
      chk(wr_cnt == base, "R6", wr_cnt - base, 0);
      if (c % 32 == 0) read_ptr("R6");
    end
    read_ptr("R6");

    // R7: early stop after 4 of 10 bytes
    set_nv_ptr(8'hFA, 8'hFE);
    base = wr_cnt;
    ev_start(); ev_byte(0, 8'hFC, a); ev_byte(1, 8'd10, a);
    for (int j = 0; j < 4; j++) ev_byte(2 + j, 8'hC0 + 8'(j), a);
    ev_stop();
    chk(wr_cnt == base + 4, "R7", wr_cnt - base, 4);
    chk(wa[base+3] == 16'hFB01 && wd[base+3] == 8'hC3, "R7",
        {8'd0, wd[base+3], wa[base+3]}, {8'd0, 8'hC3, 16'hFB01});
    exp_ptr = 16'hFB02;
    read_ptr("R7");

    // R8: bytes past the count
    set_ram_ptr(8'h90);
    base = wr_cnt;
    ev_start(); ev_byte(0, 8'hFC, a); ev_byte(1, 8'd3, a);
    for (int j = 0; j < 5; j++) begin
      ev_byte(2 + j, 8'h10 + 8'(j), a);
      chk(a === (j < 3), "R8", 32'(a), 32'(j < 3));
    end
    ev_stop();
    chk(wr_cnt == base + 3, "R8", wr_cnt - base, 3);
    exp_ptr = 16'h0093;
    read_ptr("R8");

    // R10: data after an ordinary command
    base = wr_cnt;
    ev_start(); ev_byte(0, 8'h10, a);
    chk(a === 1'b1, "R10", 32'(a), 1);
    ev_byte(1, 8'h55, a);
    chk(a === 1'b0, "R10", 32'(a), 0);
    ev_stop();
    chk(wr_cnt == base, "R10", wr_cnt - base, 0);
    read_ptr("R10");

    // R11: repeated start discards a pending program
    base = wr_cnt;
    ev_start(); ev_byte(0, 8'hF9, a); ev_byte(1, 8'h12, a); ev_byte(2, 8'h34, a);
    ev_start(); ev_stop();
    chk(wr_cnt == base, "R11", wr_cnt - base, 0);
    read_ptr("R11");

    // R12: third data byte after a nonvolatile command
    base = wr_cnt;
    ev_start(); ev_byte(0, 8'hFB, a); ev_byte(1, 8'h01, a); ev_byte(2, 8'h02, a);
    ev_byte(3, 8'h03, a);
    chk(a === 1'b0, "R12", 32'(a), 0);
    ev_stop();
    chk(wr_cnt == base, "R12", wr_cnt - base, 0);
    read_ptr("R12");

    // R9: read strobe follows the request by one cycle only
    @(negedge clk); rd_req_i = 1;
    #1 chk(be_rd_o === 1'b0, "R9", 32'(be_rd_o), 0);
    @(posedge clk); #1 rd_req_i = 0;
    @(negedge clk);
    chk(be_rd_o === 1'b1, "R9", 32'(be_rd_o), 1);
    @(negedge clk);
    chk(be_rd_o === 1'b0, "R9", 32'(be_rd_o), 0);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule